// File: doc/BRIEF.md
# Debug System Bus Access Controller

This block gives a debugger a path into system memory through three registers on a simple register port. The three registers are a control/status word, an address register and a data register. The block performs no access on its own. Each bus access is the side effect of one register access: a data write, an address write (when read-on-address is enabled) or a data read (when read-on-data is enabled). Each such trigger becomes a single 8-, 16- or 32-bit read or write on a memory bus master port. That port keeps its request raised until a response arrives. The response carries read data and an error flag.

The control word holds the access size, auto-increment, the two read triggers, a sticky error code, a sticky busy-error flag and a read-only busy flag. It also reports the supported sizes and a version number of 1. An access that is misaligned or uses an unsupported size is refused before it reaches the bus. While an error or busy-error is pending, no new access is started. A debugger clears the error code by writing back the value it read. It clears busy-error by writing 1 to that bit.

Register selects: 0 is the control word, 1 is the address register and 2 is the data register. Register reads return data combinationally in the same cycle as the request. Any side effect takes place at the clock edge that ends the request.

Top module: `dbg_sysbus_access`

## Requirements
- R1: After reset the control word reads 0x2000_3802. Its fields are: size in [2:0] = 2; bits [15:11] report the supported sizes 8/16/32/64/128 (one bit each, 8-bit in bit 11) as 0b00111; the version in [31:29] = 1. All other fields are 0.
- R2: When a data-register write is accepted while the block is idle and no error is pending, the block issues a bus write. The write uses the current address and the size from bits [2:0], where 0 = 8-bit, 1 = 16-bit and 2 = 32-bit. Write data above the access width is sent as zero.
- R3: When control bit 4 (read-on-address) is set, an accepted address write starts a bus read of the written address. The read data lands in the data register, zero-extended above the access width.
- R4: When control bit 5 (read-on-data) is set, a data-register read returns the current value and then starts a bus read at the current address.
- R5: When control bit 3 (auto-increment) is set, each access that completes without error adds 1 shifted left by the size to the address register.
- R6: Control bit 10 (busy) is 1 from the cycle after an access starts until the cycle after its response. The bus request is dropped in the cycle after the response.
- R7: An error response from the bus sets the error field [8:6] to 2. The data and address registers stay unchanged. Writing back the same nonzero code clears the field. Writing any other value leaves it unchanged.
- R8: A 16-bit access at an odd address, or a 32-bit access at an address whose low two bits are nonzero, sets the error field to 3 and issues no bus request.
- R9: An access with a size code of 3 or above sets the error field to 4 and issues no bus request.
- R10: While the error field is nonzero or busy-error is set, a trigger starts no bus access.
- R11: An address or data write while busy sets the sticky busy-error bit 9 and is dropped. Writing 1 to bit 9 clears it.
- R12: The bus request and its address, direction, size and write data stay unchanged until the response arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_req | input | 1 | Register access strobe, one cycle per access |
| reg_we | input | 1 | 1 = register write, 0 = register read |
| reg_sel | input | 2 | Register select: 0 control, 1 address, 2 data |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, valid in the request cycle |
| bus_req | output | 1 | Bus access request, held until response |
| bus_we | output | 1 | 1 = bus write, 0 = bus read |
| bus_addr | output | ADDR_W | Bus byte address |
| bus_size | output | 3 | Access size code (0, 1 or 2) |
| bus_wdata | output | DATA_W | Write data, low-aligned |
| bus_rsp_valid | input | 1 | Response strobe for the pending request |
| bus_rsp_rdata | input | DATA_W | Read data, low-aligned |
| bus_rsp_err | input | 1 | Response reports a bad address |

## Verification
The hardest condition to reach from the ports is busy-error. It needs a second address or data write to land while the bus is still waiting on a response. The stimulus gets there with a responder model that holds every response back for several cycles, and it fires an address write two cycles after a data-write trigger. The bench then reads back the address register to show that the late write was dropped. It also shows that a later trigger stays blocked until the bit is cleared. The refused cases (misalignment, oversize, pending error) are caught by a scoreboard. Any bus request that arrives with no expected item in the queue counts as a failure.

// File: rtl/dsba_pkg.sv
// Package: shared constants for the debug system bus access controller.
// Assumes a 32-bit register window; field positions below are the
// control-word layout seen by the debugger.
package dsba_pkg;

    localparam int REG_W = 32;

    typedef enum logic [1:0] {
        SEL_CTRL = 2'd0,
        SEL_ADDR = 2'd1,
        SEL_DATA = 2'd2
    } reg_sel_e;

    typedef enum logic [2:0] {
        ERR_NONE    = 3'd0,
        ERR_BADADDR = 3'd2,
        ERR_ALIGN   = 3'd3,
        ERR_SIZE    = 3'd4
    } err_code_e;

    // Control word bit positions.
    localparam int F_SIZE_LO  = 0;
    localparam int F_AUTOINC  = 3;
    localparam int F_RD_ADDR  = 4;
    localparam int F_RD_DATA  = 5;
    localparam int F_ERR_LO   = 6;
    localparam int F_BUSYERR  = 9;
    localparam int F_BUSY     = 10;
    localparam int F_CAPS_LO  = 11;
    localparam int F_VER_LO   = 29;

    localparam logic [2:0] RESET_SIZE = 3'd2;

endpackage

// File: rtl/dsba_ctrl_reg.sv
// Module: control/status register.
// Holds size, auto-increment, the two read triggers, the sticky error
// code and the sticky busy-error flag, and assembles the read word.
// Assumes err_set and berr_set are single-cycle pulses; a set in the
// same cycle as a clearing write wins.
module dsba_ctrl_reg
    import dsba_pkg::*;
#(
    parameter logic [4:0] CAPS    = 5'b00111,
    parameter logic [2:0] VERSION = 3'd1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [9:0]       wr_bits,
    input  logic             err_set,
    input  logic [2:0]       err_code,
    input  logic             berr_set,
    input  logic             busy,
    output logic [2:0]       size,
    output logic             autoinc,
    output logic             rd_on_addr,
    output logic             rd_on_data,
    output logic [2:0]       err,
    output logic             busy_err,
    output logic [REG_W-1:0] ctrl_word
);

    logic [2:0] wr_err;
    assign wr_err = wr_bits[F_ERR_LO +: 3];

    // Plain read/write fields: updated on any control write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            size       <= RESET_SIZE;
            autoinc    <= 1'b0;
            rd_on_addr <= 1'b0;
            rd_on_data <= 1'b0;
        end else if (wr_en) begin
            size       <= wr_bits[F_SIZE_LO +: 3];
            autoinc    <= wr_bits[F_AUTOINC];
            rd_on_addr <= wr_bits[F_RD_ADDR];
            rd_on_data <= wr_bits[F_RD_DATA];
        end
    end

    // Sticky error code: set by a fault, cleared by writing the same code back.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err <= ERR_NONE;
        end else if (err_set) begin
            err <= err_code;
        end else if (wr_en && (wr_err != ERR_NONE) && (wr_err == err)) begin
            err <= ERR_NONE;
        end
    end

    // Sticky busy-error: set on a collision, cleared by writing one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_err <= 1'b0;
        end else if (berr_set) begin
            busy_err <= 1'b1;
        end else if (wr_en && wr_bits[F_BUSYERR]) begin
            busy_err <= 1'b0;
        end
    end

    // Read word assembly.
    always_comb begin
        ctrl_word                   = '0;
        ctrl_word[F_SIZE_LO +: 3]   = size;
        ctrl_word[F_AUTOINC]        = autoinc;
        ctrl_word[F_RD_ADDR]        = rd_on_addr;
        ctrl_word[F_RD_DATA]        = rd_on_data;
        ctrl_word[F_ERR_LO +: 3]    = err;
        ctrl_word[F_BUSYERR]        = busy_err;
        ctrl_word[F_BUSY]           = busy;
        ctrl_word[F_CAPS_LO +: 5]   = CAPS;
        ctrl_word[F_VER_LO +: 3]    = VERSION;
    end

endmodule

// File: rtl/dsba_access_check.sv
// Module: pre-bus legality check of a requested access.
// Refuses sizes above the widest implemented one (or not in CAPS) with
// the size code, then misaligned addresses with the alignment code.
// Purely combinational; only the low address bits matter.
module dsba_access_check
    import dsba_pkg::*;
#(
    parameter logic [4:0] CAPS     = 5'b00111,
    parameter int         MAX_CODE = 2
) (
    input  logic [2:0] size,
    input  logic [1:0] addr_lo,
    output logic       ok,
    output logic [2:0] code
);

    logic       size_ok;
    logic [1:0] low_mask;

    // Size legality: implemented and advertised.
    always_comb begin
        size_ok = 1'b0;
        if ((int'(size) <= MAX_CODE) && (size < 3'd5)) begin
            size_ok = CAPS[size];
        end
    end

    // Address bits that must be zero for the selected size.
    always_comb begin
        case (size)
            3'd0:    low_mask = 2'b00;
            3'd1:    low_mask = 2'b01;
            default: low_mask = 2'b11;
        endcase
    end

    // Verdict, size fault first.
    always_comb begin
        if (!size_ok) begin
            ok   = 1'b0;
            code = ERR_SIZE;
        end else if ((addr_lo & low_mask) != 2'b00) begin
            ok   = 1'b0;
            code = ERR_ALIGN;
        end else begin
            ok   = 1'b1;
            code = ERR_NONE;
        end
    end

endmodule

// File: rtl/dsba_bus_engine.sv
// Module: address/data registers and the single-access bus master.
// Launches one access on start, holds the request until the response,
// then updates data (reads) and address (auto-increment) on success.
// Assumes the caller never asserts start or a load while busy.
module dsba_bus_engine #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              addr_load,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              data_load,
    input  logic [DATA_W-1:0] data_in,
    input  logic              start,
    input  logic              start_we,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [2:0]        start_size,
    input  logic              start_inc,
    output logic              bus_req,
    output logic              bus_we,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [2:0]        bus_size,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_rsp_valid,
    input  logic [DATA_W-1:0] bus_rsp_rdata,
    input  logic              bus_rsp_err,
    output logic [ADDR_W-1:0] addr_q,
    output logic [DATA_W-1:0] data_q,
    output logic              rsp_fail
);

    logic inc_q;
    logic done;

    // Lanes that carry data for a given size code.
    function automatic logic [DATA_W-1:0] lane_mask(input logic [2:0] s);
        case (s)
            3'd0:    lane_mask = DATA_W'(8'hFF);
            3'd1:    lane_mask = DATA_W'(16'hFFFF);
            default: lane_mask = '1;
        endcase
    endfunction

    assign done     = bus_req && bus_rsp_valid;
    assign rsp_fail = done && bus_rsp_err;

    // Bus request register: raise on start, drop on response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_req   <= 1'b0;
            bus_we    <= 1'b0;
            bus_addr  <= '0;
            bus_size  <= '0;
            bus_wdata <= '0;
            inc_q     <= 1'b0;
        end else if (start) begin
            bus_req   <= 1'b1;
            bus_we    <= start_we;
            bus_addr  <= start_addr;
            bus_size  <= start_size;
            bus_wdata <= start_we ? (data_in & lane_mask(start_size)) : '0;
            inc_q     <= start_inc;
        end else if (done) begin
            bus_req   <= 1'b0;
        end
    end

    // Address register: debugger load, or step after a clean access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
        end else if (done) begin
            if (!bus_rsp_err && inc_q) begin
                addr_q <= addr_q + (ADDR_W'(1) << bus_size);
            end
        end else if (addr_load) begin
            addr_q <= addr_in;
        end
    end

    // Data register: debugger load, or read result zero-extended.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
        end else if (done) begin
            if (!bus_rsp_err && !bus_we) begin
                data_q <= bus_rsp_rdata & lane_mask(bus_size);
            end
        end else if (data_load) begin
            data_q <= data_in;
        end
    end

endmodule

// File: rtl/dbg_sysbus_access.sv
// Module: debug system bus access controller (top).
// Decodes register accesses, turns the triggering ones into bus
// accesses, and flags collisions and refused requests.
// Assumes one register access per reg_req cycle; read data is combinational.
module dbg_sysbus_access
    import dsba_pkg::*;
#(
    parameter int         ADDR_W    = 32,
    parameter int         DATA_W    = 32,
    parameter logic [4:0] SIZE_CAPS = 5'b00111
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_req,
    input  logic              reg_we,
    input  logic [1:0]        reg_sel,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    output logic              bus_req,
    output logic              bus_we,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [2:0]        bus_size,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_rsp_valid,
    input  logic [DATA_W-1:0] bus_rsp_rdata,
    input  logic              bus_rsp_err
);

    localparam int         MAX_CODE  = $clog2(DATA_W / 8);
    localparam logic [4:0] IMPL_MASK = 5'((1 << (MAX_CODE + 1)) - 1);
    localparam logic [4:0] EFF_CAPS  = SIZE_CAPS & IMPL_MASK;

    logic              wr_ctrl, wr_addr, wr_data, rd_data;
    logic [2:0]        size_q;
    logic              autoinc_q, rda_q, rdd_q;
    logic [2:0]        err_q;
    logic              berr_q;
    logic [REG_W-1:0]  ctrl_word;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] data_q;
    logic              busy;
    logic              blocked, trig, chk_ok, start, rsp_fail;
    logic [2:0]        chk_code;
    logic [ADDR_W-1:0] chk_addr;
    logic              err_set;
    logic [2:0]        err_code;
    logic              busy_hit;

    // Register access decode.
    always_comb begin
        wr_ctrl = reg_req &&  reg_we && (reg_sel == SEL_CTRL);
        wr_addr = reg_req &&  reg_we && (reg_sel == SEL_ADDR);
        wr_data = reg_req &&  reg_we && (reg_sel == SEL_DATA);
        rd_data = reg_req && !reg_we && (reg_sel == SEL_DATA);
    end

    assign busy = bus_req;

    // Trigger evaluation against the current sticky state.
    always_comb begin
        busy_hit = busy && (wr_addr || wr_data);
        blocked  = (err_q != ERR_NONE) || berr_q;
        trig     = !busy && !blocked &&
                   ((wr_addr && rda_q) || wr_data || (rd_data && rdd_q));
        chk_addr = wr_addr ? reg_wdata[ADDR_W-1:0] : addr_q;
        start    = trig && chk_ok;
        err_set  = (trig && !chk_ok) || rsp_fail;
        err_code = rsp_fail ? ERR_BADADDR : chk_code;
    end

    // Read data mux.
    always_comb begin
        case (reg_sel)
            SEL_CTRL: reg_rdata = ctrl_word;
            SEL_ADDR: reg_rdata = REG_W'(addr_q);
            SEL_DATA: reg_rdata = REG_W'(data_q);
            default:  reg_rdata = '0;
        endcase
    end

    dsba_ctrl_reg #(
        .CAPS    (EFF_CAPS),
        .VERSION (3'd1)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_ctrl),
        .wr_bits    (reg_wdata[9:0]),
        .err_set    (err_set),
        .err_code   (err_code),
        .berr_set   (busy_hit),
        .busy       (busy),
        .size       (size_q),
        .autoinc    (autoinc_q),
        .rd_on_addr (rda_q),
        .rd_on_data (rdd_q),
        .err        (err_q),
        .busy_err   (berr_q),
        .ctrl_word  (ctrl_word)
    );

    dsba_access_check #(
        .CAPS     (EFF_CAPS),
        .MAX_CODE (MAX_CODE)
    ) u_check (
        .size    (size_q),
        .addr_lo (chk_addr[1:0]),
        .ok      (chk_ok),
        .code    (chk_code)
    );

    dsba_bus_engine #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_engine (
        .clk           (clk),
        .rst_n         (rst_n),
        .addr_load     (wr_addr && !busy),
        .addr_in       (reg_wdata[ADDR_W-1:0]),
        .data_load     (wr_data && !busy),
        .data_in       (reg_wdata[DATA_W-1:0]),
        .start         (start),
        .start_we      (wr_data),
        .start_addr    (chk_addr),
        .start_size    (size_q),
        .start_inc     (autoinc_q),
        .bus_req       (bus_req),
        .bus_we        (bus_we),
        .bus_addr      (bus_addr),
        .bus_size      (bus_size),
        .bus_wdata     (bus_wdata),
        .bus_rsp_valid (bus_rsp_valid),
        .bus_rsp_rdata (bus_rsp_rdata),
        .bus_rsp_err   (bus_rsp_err),
        .addr_q        (addr_q),
        .data_q        (data_q),
        .rsp_fail      (rsp_fail)
    );

endmodule

// File: rtl/dsba_checker.sv
// Module: protocol checker for the bus access controller, bound to the top.
// Observes the bus port and the sticky error state.
module dsba_checker #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_req,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [2:0]        bus_size,
    input logic              bus_rsp_valid,
    input logic              bus_rsp_err,
    input logic [2:0]        err,
    input logic              busy_err
);

    // R12: request and its fields hold until a response.
    assert_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && !bus_rsp_valid |=> bus_req && $stable(bus_addr) &&
                                      $stable(bus_we) && $stable(bus_size));

    // R6: request drops right after its response.
    assert_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && bus_rsp_valid |=> !bus_req);

    // R9: no oversize access reaches the bus.
    assert_size_R9: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req |-> bus_size <= 3'd2);

    // R8: no misaligned access reaches the bus.
    assert_align_R8: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req |-> !((bus_size == 3'd1 && bus_addr[0]) ||
                      (bus_size == 3'd2 && bus_addr[1:0] != 2'b00)));

    // R10: a pending error keeps the bus quiet.
    assert_block_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_req && (err != 3'd0 || busy_err) |=> !bus_req);

    // R7: an error response records code 2.
    assert_err_R7: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && bus_rsp_valid && bus_rsp_err |=> err == 3'd2);

endmodule

bind dbg_sysbus_access dsba_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .bus_req       (bus_req),
    .bus_we        (bus_we),
    .bus_addr      (bus_addr),
    .bus_size      (bus_size),
    .bus_rsp_valid (bus_rsp_valid),
    .bus_rsp_err   (bus_rsp_err),
    .err           (err_q),
    .busy_err      (berr_q)
);

// File: tb/dbg_sysbus_access_tb.sv
// Scoreboard bench: tasks push expected bus items, a responder process
// pops and compares them and models a byte memory with slow responses.
module dbg_sysbus_access_tb;

    localparam int CLK_PERIOD = 10;
    localparam int LAT        = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_req = 1'b0;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_sel = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        bus_req, bus_we;
    logic [31:0] bus_addr;
    logic [2:0]  bus_size;
    logic [31:0] bus_wdata;
    logic        bus_rsp_valid = 1'b0;
    logic [31:0] bus_rsp_rdata = '0;
    logic        bus_rsp_err = 1'b0;

    int checks = 0;
    int bad = 0;
    bit finished = 0;

    logic [67:0] exp_q[$];
    logic [7:0]  mem[256];

    always #(CLK_PERIOD / 2) clk = ~clk;

    dbg_sysbus_access u_dut (
        .clk(clk), .rst_n(rst_n), .reg_req(reg_req), .reg_we(reg_we),
        .reg_sel(reg_sel), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_size(bus_size), .bus_wdata(bus_wdata),
        .bus_rsp_valid(bus_rsp_valid), .bus_rsp_rdata(bus_rsp_rdata),
        .bus_rsp_err(bus_rsp_err)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] cv(input int sz, input bit ai, input bit rda,
                                       input bit rdd, input int er, input bit be);
        cv = 32'(sz) | (32'(ai) << 3) | (32'(rda) << 4) | (32'(rdd) << 5) |
             (32'(er) << 6) | (32'(be) << 9);
    endfunction

    task automatic rw(input logic [1:0] s, input logic [31:0] d);
        @(negedge clk);
        reg_req = 1'b1; reg_we = 1'b1; reg_sel = s; reg_wdata = d;
        @(negedge clk);
        reg_req = 1'b0; reg_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] s, output logic [31:0] v);
        @(negedge clk);
        reg_req = 1'b1; reg_we = 1'b0; reg_sel = s;
        #1 v = reg_rdata;
        @(negedge clk);
        reg_req = 1'b0;
    endtask

    task automatic rd_chk(input logic [1:0] s, input logic [31:0] mask,
                          input logic [31:0] exp, input string tag);
        logic [31:0] v;
        rd(s, v);
        chk(tag, v & mask, exp & mask);
    endtask

    task automatic expect_bus(input bit we, input logic [31:0] a, input int sz,
                              input logic [31:0] wd);
        exp_q.push_back({we, a, 3'(sz), wd});
    endtask

    task automatic wait_idle();
        logic [31:0] v;
        for (int i = 0; i < 100; i++) begin
            rd(2'd0, v);
            if (!v[10] && !bus_rsp_valid) break;
        end
        repeat (2) @(negedge clk);
    endtask

    // Responder/monitor: scoreboard compare, field hold, memory model.
    always @(negedge clk) begin : responder
        static bit pend = 0;
        static int cnt = 0;
        static logic [67:0] cap = '0;
        if (!rst_n) begin
            pend = 0; bus_rsp_valid = 1'b0;
        end else if (bus_rsp_valid) begin
            bus_rsp_valid = 1'b0; bus_rsp_err = 1'b0; pend = 0;
        end else if (pend) begin
            checks++;
            if ({bus_we, bus_addr, bus_size, bus_wdata} !== cap) begin
                bad++;
                $display("FAIL R12: actual=%h expected=%h",
                         {bus_we, bus_addr, bus_size, bus_wdata}, cap);
            end
            if (cnt == 0) begin
                bus_rsp_valid = 1'b1;
                bus_rsp_err = bus_addr[31];
                bus_rsp_rdata = '0;
                if (!bus_addr[31]) begin
                    if (bus_we) begin
                        for (int b = 0; b < (1 << bus_size); b++)
                            mem[8'(bus_addr[7:0] + b)] = bus_wdata[8*b +: 8];
                    end else begin
                        for (int b = 0; b < 4; b++)
                            bus_rsp_rdata[8*b +: 8] = mem[8'(bus_addr[7:0] + b)];
                    end
                end
            end else begin
                cnt--;
            end
        end else if (bus_req) begin
            pend = 1; cnt = LAT;
            cap = {bus_we, bus_addr, bus_size, bus_wdata};
            checks++;
            if (exp_q.size() == 0) begin
                bad++;
                $display("FAIL R2/R8/R9/R10: actual=unexpected request %h expected=none", cap);
            end else begin
                logic [67:0] e;
                e = exp_q.pop_front();
                if (e !== cap) begin
                    bad++;
                    $display("FAIL R2/R3/R4/R5: actual=%h expected=%h", cap, e);
                end
            end
        end
    end

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!finished) begin
            bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end

    initial begin : stim
        for (int i = 0; i < 256; i++) mem[i] = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        rd_chk(2'd0, '1, 32'h2000_3802, "R1 ctrl reset");
        chk("R1 no request", 32'(bus_req), 32'd0);

        // R2: 32-bit write, then busy visible (R6)
        rw(2'd0, cv(2, 0, 0, 0, 0, 0));
        rw(2'd1, 32'h10);
        expect_bus(1, 32'h10, 2, 32'hDEAD_BEEF);
        rw(2'd2, 32'hDEAD_BEEF);
        rd_chk(2'd0, 32'h400, 32'h400, "R6 busy during access");
        wait_idle();
        rd_chk(2'd0, 32'h400, 32'h0, "R6 busy cleared");
        // R2: narrow writes carry zero above width
        rw(2'd0, cv(0, 0, 0, 0, 0, 0));
        rw(2'd1, 32'h21);
        expect_bus(1, 32'h21, 0, 32'hA5);
        rw(2'd2, 32'h1234_56A5);
        wait_idle();
        rw(2'd0, cv(1, 0, 0, 0, 0, 0));
        rw(2'd1, 32'h32);
        expect_bus(1, 32'h32, 1, 32'hBEEF);
        rw(2'd2, 32'hFFFF_BEEF);
        wait_idle();

        // R3: read-on-address, zero-extended results
        rw(2'd0, cv(2, 0, 1, 0, 0, 0));
        expect_bus(0, 32'h10, 2, 0);
        rw(2'd1, 32'h10);
        wait_idle();
        rd_chk(2'd2, '1, 32'hDEAD_BEEF, "R3 word read");
        rw(2'd0, cv(0, 0, 1, 0, 0, 0));
        expect_bus(0, 32'h11, 0, 0);
        rw(2'd1, 32'h11);
        wait_idle();
        rd_chk(2'd2, '1, 32'h0000_00BE, "R3 byte read zero-extended");
        rw(2'd0, cv(1, 0, 1, 0, 0, 0));
        expect_bus(0, 32'h12, 1, 0);
        rw(2'd1, 32'h12);
        wait_idle();
        rd_chk(2'd2, '1, 32'h0000_DEAD, "R3 half read zero-extended");

        // R5: auto-increment on writes
        rw(2'd0, cv(2, 1, 0, 0, 0, 0));
        rw(2'd1, 32'h40);
        expect_bus(1, 32'h40, 2, 32'h11); rw(2'd2, 32'h11); wait_idle();
        expect_bus(1, 32'h44, 2, 32'h22); rw(2'd2, 32'h22); wait_idle();
        expect_bus(1, 32'h48, 2, 32'h33); rw(2'd2, 32'h33); wait_idle();
        rd_chk(2'd1, '1, 32'h4C, "R5 word increment");
        // R4: read-on-data with priming read
        rw(2'd0, cv(2, 1, 0, 1, 0, 0));
        rw(2'd1, 32'h40);
        expect_bus(0, 32'h40, 2, 0);
        rd_chk(2'd2, '1, 32'h33, "R4 priming read returns old value");
        wait_idle();
        expect_bus(0, 32'h44, 2, 0);
        rd_chk(2'd2, '1, 32'h11, "R4 first word");
        wait_idle();
        expect_bus(0, 32'h48, 2, 0);
        rd_chk(2'd2, '1, 32'h22, "R4 second word");
        wait_idle();
        rw(2'd0, cv(2, 1, 0, 0, 0, 0));
        rd_chk(2'd2, '1, 32'h33, "R4 third word, no trigger when off");
        rd_chk(2'd1, '1, 32'h4C, "R5 increment after reads");
        rw(2'd0, cv(0, 1, 0, 0, 0, 0));
        rw(2'd1, 32'h60);
        expect_bus(1, 32'h60, 0, 32'h01); rw(2'd2, 32'h01); wait_idle();
        expect_bus(1, 32'h61, 0, 32'h02); rw(2'd2, 32'h02); wait_idle();
        rd_chk(2'd1, '1, 32'h62, "R5 byte increment");

        // R7: bus error
        rw(2'd0, cv(2, 1, 1, 0, 0, 0));
        expect_bus(0, 32'h8000_0000, 2, 0);
        rw(2'd1, 32'h8000_0000);
        wait_idle();
        rd_chk(2'd0, 32'h1C0, 32'h080, "R7 error code 2");
        rd_chk(2'd1, '1, 32'h8000_0000, "R7 no increment on error");
        rd_chk(2'd2, '1, 32'h0000_0002, "R7 data unchanged");
        rw(2'd0, cv(2, 0, 0, 0, 3, 0));
        rd_chk(2'd0, 32'h1C0, 32'h080, "R7 wrong code keeps error");
        rw(2'd0, cv(2, 0, 0, 0, 2, 0));
        rd_chk(2'd0, 32'h1C0, 32'h000, "R7 cleared by write-back");

        // R8: misaligned, R10: blocked while pending
        rw(2'd1, 32'h42);
        rw(2'd2, 32'h55);
        repeat (4) @(negedge clk);
        rd_chk(2'd0, 32'h1C0, 32'h0C0, "R8 misaligned code 3");
        rw(2'd0, cv(1, 0, 0, 0, 0, 0));
        rw(2'd2, 32'h66);
        repeat (4) @(negedge clk);
        rd_chk(2'd0, 32'h1C0, 32'h0C0, "R10 blocked while error pending");
        rw(2'd0, cv(1, 0, 0, 0, 3, 0));
        expect_bus(1, 32'h42, 1, 32'h77);
        rw(2'd2, 32'h77);
        wait_idle();
        rd_chk(2'd0, 32'h1C0, 32'h000, "R10 resumes after clear");

        // R9: unsupported sizes
        rw(2'd0, cv(3, 0, 0, 0, 0, 0));
        rw(2'd2, 32'h88);
        repeat (4) @(negedge clk);
        rd_chk(2'd0, 32'h1C0, 32'h100, "R9 size 3 code 4");
        rw(2'd0, cv(4, 0, 0, 0, 4, 0));
        rw(2'd2, 32'h89);
        repeat (4) @(negedge clk);
        rd_chk(2'd0, 32'h1C0, 32'h100, "R9 size 4 code 4");
        rw(2'd0, cv(2, 0, 0, 0, 4, 0));

        // R11: collision during access
        rw(2'd1, 32'h70);
        expect_bus(1, 32'h70, 2, 32'hAA);
        rw(2'd2, 32'hAA);
        rw(2'd1, 32'h90);
        wait_idle();
        rd_chk(2'd0, 32'h200, 32'h200, "R11 busy-error set");
        rd_chk(2'd1, '1, 32'h70, "R11 colliding write dropped");
        rw(2'd2, 32'hBB);
        repeat (4) @(negedge clk);
        rd_chk(2'd0, 32'h200, 32'h200, "R10 blocked by busy-error");
        rw(2'd0, cv(2, 0, 0, 0, 0, 1));
        rd_chk(2'd0, 32'h200, 32'h000, "R11 cleared by writing one");
        expect_bus(1, 32'h70, 2, 32'hCC);
        rw(2'd2, 32'hCC);
        wait_idle();

        chk("R2 scoreboard drained", 32'(exp_q.size()), 32'd0);
        finished = 1;
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

endmodule